// File: doc/BRIEF.md
# Operand-Conflict Interlock for a Four-Stage Pipeline

This unit finds read-after-write conflicts in a pipeline with four stages: fetch, operand read, execute/memory and register write-back. Each cycle it looks at the instruction sitting in operand read. It compares that instruction's source register indices with the destinations of the older instructions still in flight. The unit records those older instructions itself, in a short shadow of the execute and write-back stages. A register file write lands at the end of the write-back cycle, so a producer that is in execute or in write-back still blocks the read. On a conflict the unit raises `stall`, which freezes the PC, the instruction register and the operand-read stage. In the same cycle it raises `bubble`, which sends an invalid slot into execute. The older stages keep draining, so the stall clears by itself.

The unit also tracks instructions that write the PC. The new PC is used only by the fetch that comes four cycles after the branch was fetched. For that reason `squash_if` stays high while a valid PC writer is in operand read, in execute or in write-back. During those cycles the surrounding pipeline clears the valid bit of the instruction it has just fetched, and it restarts fetch at the new PC. As a result, code without hand-placed no-ops runs correctly.

All ports are plain control pins with no handshake. The surrounding pipeline must keep the operand-read inputs stable while `stall` is high. After a cycle in which `squash_if` was high and `stall` was low, it must present `rd_valid` low.

Top module: `op_interlock`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `stall`, `bubble` and `squash_if` are low. No instruction from before reset counts as a producer.
- R2: A valid operand-read instruction whose enabled source A or source B equals the destination of the valid, register-writing instruction one cycle ahead (in execute) raises `stall` and `bubble` in that same cycle.
- R3: A matching producer in write-back also raises `stall`, because its write is not visible until the next cycle.
- R4: A reader placed directly behind its producer stalls for exactly 2 cycles. With one unrelated instruction or idle slot between them it stalls for exactly 1 cycle. With two or more between them it does not stall.
- R5: No stall results when the matching source's enable is low, when the older instruction's write enable is low, or when the older slot is invalid.
- R6: The slot that enters execute during a stall is invalid and never counts as a producer. The stalled instruction is recorded exactly once, when it advances, so a later reader of its destination stalls exactly 2 cycles.
- R7: `squash_if` is high in the cycle a valid PC-writing instruction is in operand read, and in each of the next two cycles as it passes through execute and write-back. It is low in the cycle after that, provided no other PC writer is in flight.
- R8: When `rd_valid` is low, `stall` and `bubble` are low, whatever the source fields hold.
- R9: `bubble` equals `stall` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Operand-read stage holds a real instruction |
| src_a | input | 5 | First source register index |
| src_a_en | input | 1 | First source is read (also set for a store's data register) |
| src_b | input | 5 | Second source register index |
| src_b_en | input | 1 | Second source is read |
| dst | input | 5 | Destination register index of the operand-read instruction |
| dst_wen | input | 1 | Instruction writes a register |
| pc_wr | input | 1 | Instruction writes the PC |
| stall | output | 1 | Hold PC, instruction register and operand-read stage |
| bubble | output | 1 | Send an invalid slot into execute |
| squash_if | output | 1 | Clear the valid bit of the instruction just fetched |

## Verification
All three outputs are combinational in the cycle the operand-read inputs are presented. Producer state is registered at the rising edge, so a producer affects reads in the first and second cycles after it advances. The bench therefore drives inputs at the falling edge and compares the outputs 1 ns later, before the next rising edge. A bench model ages its own record of advanced instructions at that same point. Stall counts per instruction and squash windows are also compared with the fixed values that R4, R6 and R7 give.

// File: rtl/oi_pkg.sv
package oi_pkg;
  parameter int REG_W = 5;

  // one in-flight instruction as seen by the interlock
  typedef struct packed {
    logic             valid;
    logic             wen;
    logic             pcw;
    logic [REG_W-1:0] rd;
  } slot_t;
endpackage

// File: rtl/oi_track.sv
module oi_track
  import oi_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  inject_bubble,
  input  slot_t rd_slot,
  output slot_t slots [DEPTH]
);
  slot_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)             slot_q[0] <= '0;
        else if (inject_bubble) slot_q[0] <= '0;
        else                    slot_q[0] <= rd_slot;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) slot_q[g] <= '0;
        else        slot_q[g] <= slot_q[g-1];
      end
    end
    assign slots[g] = slot_q[g];
  end

  AST_BUBBLE_IS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    inject_bubble |=> !slot_q[0].valid); // R6
endmodule

// File: rtl/oi_src_match.sv
module oi_src_match
  import oi_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  slot_t            slots [DEPTH],
  input  logic [REG_W-1:0] src,
  input  logic             src_en,
  output logic             hit
);
  logic [DEPTH-1:0] per_slot;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign per_slot[g] = slots[g].valid && slots[g].wen && (slots[g].rd == src);
  end

  assign hit = src_en && (|per_slot);
endmodule

// File: rtl/op_interlock.sv
module op_interlock
  import oi_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic [REG_W-1:0] src_a,
  input  logic             src_a_en,
  input  logic [REG_W-1:0] src_b,
  input  logic             src_b_en,
  input  logic [REG_W-1:0] dst,
  input  logic             dst_wen,
  input  logic             pc_wr,
  output logic             stall,
  output logic             bubble,
  output logic             squash_if
);
  localparam int N_SRC = 2;
  localparam int RUN_W = $clog2(DEPTH + 2);

  slot_t            inflight [DEPTH];
  slot_t            rd_slot;
  logic [REG_W-1:0] src_idx [N_SRC];
  logic [N_SRC-1:0] src_on;
  logic [N_SRC-1:0] src_hit;
  logic [DEPTH-1:0] pcw_live;
  logic             hazard;

  assign src_idx[0] = src_a;
  assign src_idx[1] = src_b;
  assign src_on     = {src_b_en, src_a_en};

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    oi_src_match #(.DEPTH(DEPTH)) u_match (
      .slots  (inflight),
      .src    (src_idx[s]),
      .src_en (src_on[s]),
      .hit    (src_hit[s])
    );
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_pcw
    assign pcw_live[g] = inflight[g].valid && inflight[g].pcw;
  end

  assign hazard    = rd_valid && (|src_hit);
  assign stall     = hazard;
  assign bubble    = hazard;
  assign squash_if = (rd_valid && pc_wr) || (|pcw_live);

  assign rd_slot = '{valid: rd_valid, wen: dst_wen, pcw: pc_wr, rd: dst};

  oi_track #(.DEPTH(DEPTH)) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .inject_bubble (hazard),
    .rd_slot       (rd_slot),
    .slots         (inflight)
  );

  // length of the current run of stalled cycles, for the bound check
  logic [RUN_W-1:0] stall_run;
  always_ff @(posedge clk) begin
    if (!rst_n)     stall_run <= '0;
    else if (stall) stall_run <= stall_run + 1'b1;
    else            stall_run <= '0;
  end

  AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    stall_run <= RUN_W'(DEPTH)); // R4
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !stall); // R8
  AST_PCW_KEEPS_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && pc_wr && !stall) |=> squash_if); // R7
  AST_BUBBLE_TRACKS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    bubble == stall); // R9
endmodule

// File: tb/op_interlock_bench.sv
module op_interlock_bench;
  import oi_pkg::*;

  typedef struct packed {
    logic v, a_en, b_en, wen, pcw;
    logic [REG_W-1:0] a, b, rd;
  } ins_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_valid = 0, src_a_en = 0, src_b_en = 0, dst_wen = 0, pc_wr = 0;
  logic [REG_W-1:0] src_a = '0, src_b = '0, dst = '0;
  logic stall, bubble, squash_if;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  op_interlock u_op_interlock (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid),
    .src_a(src_a), .src_a_en(src_a_en), .src_b(src_b), .src_b_en(src_b_en),
    .dst(dst), .dst_wen(dst_wen), .pc_wr(pc_wr),
    .stall(stall), .bubble(bubble), .squash_if(squash_if)
  );

  // bench record of instructions that advanced one and two cycles ago
  ins_t age1 = '0, age2 = '0;

  function automatic logic writes(ins_t p, logic [REG_W-1:0] r);
    return p.v && p.wen && (p.rd == r);
  endfunction

  function automatic logic want_stall(ins_t i);
    if (!i.v) return 1'b0;
    return (i.a_en && (writes(age1, i.a) || writes(age2, i.a))) ||
           (i.b_en && (writes(age1, i.b) || writes(age2, i.b)));
  endfunction

  function automatic logic want_squash(ins_t i);
    return (i.v && i.pcw) || (age1.v && age1.pcw) || (age2.v && age2.pcw);
  endfunction

  function automatic ins_t mk(logic v, logic ae, logic [REG_W-1:0] a, logic be,
                              logic [REG_W-1:0] b, logic w, logic [REG_W-1:0] rd,
                              logic pcw);
    ins_t t;
    t.v = v; t.a_en = ae; t.a = a; t.b_en = be; t.b = b;
    t.wen = w; t.rd = rd; t.pcw = pcw;
    return t;
  endfunction

  task automatic check_bit(string tag, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_int(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle(ins_t i, string tag, output logic st, output logic sq);
    logic es, eq;
    @(negedge clk);
    rd_valid = i.v; src_a_en = i.a_en; src_a = i.a; src_b_en = i.b_en;
    src_b = i.b; dst_wen = i.wen; dst = i.rd; pc_wr = i.pcw;
    #1;
    es = want_stall(i);
    eq = want_squash(i);
    check_bit(tag, "stall", stall, es);
    check_bit({tag, " R9"}, "bubble", bubble, es);
    check_bit(tag, "squash_if", squash_if, eq);
    age2 = age1;
    age1 = es ? ins_t'('0) : i;
    st = es;
    sq = eq;
  endtask

  task automatic issue(ins_t i, string tag, output int stalls, output logic sq);
    logic st;
    stalls = 0;
    do begin
      cycle(i, tag, st, sq);
      if (st) stalls++;
    end while (st && stalls < 8);
  endtask

  ins_t idle_i;

  initial begin
    int n;
    logic sq;
    idle_i = '0;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check_bit("R1", "stall in reset", stall, 1'b0);
    check_bit("R1", "squash_if in reset", squash_if, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    issue(mk(1,1,5'd3,1,5'd0,0,5'd0,0), "R1 empty after reset", n, sq);
    check_int("R1", "stalls after reset", n, 0);

    // R2 and R4: back to back on source A, then on source B
    issue(mk(1,0,0,0,0,1,5'd5,0), "R2 producer", n, sq);
    issue(mk(1,1,5'd5,0,0,0,0,0), "R2 reader A", n, sq);
    check_int("R4", "back-to-back stalls A", n, 2);
    issue(mk(1,0,0,0,0,1,5'd9,0), "R2 producer", n, sq);
    issue(mk(1,0,0,1,5'd9,1,5'd1,0), "R2 reader B", n, sq);
    check_int("R4", "back-to-back stalls B", n, 2);

    // R3: one gap, producer in write-back
    issue(mk(1,0,0,0,0,1,5'd6,0), "R3 producer", n, sq);
    issue(idle_i, "R3 gap", n, sq);
    issue(mk(1,1,5'd6,0,0,0,0,0), "R3 reader", n, sq);
    check_int("R3", "one-gap stalls", n, 1);

    // R4: two gaps, no stall
    issue(mk(1,0,0,0,0,1,5'd7,0), "R4 producer", n, sq);
    issue(mk(1,1,5'd2,0,0,0,0,0), "R4 filler", n, sq);
    issue(idle_i, "R4 gap", n, sq);
    issue(mk(1,1,5'd7,1,5'd7,0,0,0), "R4 reader", n, sq);
    check_int("R4", "two-gap stalls", n, 0);

    // R5: enable off, producer not writing, producer invalid
    issue(mk(1,0,0,0,0,1,5'd8,0), "R5 producer", n, sq);
    issue(mk(1,0,5'd8,0,5'd8,0,0,0), "R5 sources off", n, sq);
    check_int("R5", "source disabled stalls", n, 0);
    issue(mk(1,0,0,0,0,0,5'd10,0), "R5 no write", n, sq);
    issue(mk(1,1,5'd10,0,0,0,0,0), "R5 reader", n, sq);
    check_int("R5", "no-write producer stalls", n, 0);
    issue(mk(0,0,0,0,0,1,5'd11,0), "R5 invalid producer", n, sq);
    issue(mk(1,1,5'd11,0,0,0,0,0), "R5 reader", n, sq);
    check_int("R5", "invalid producer stalls", n, 0);

    // R8: idle operand-read slot with matching fields
    issue(mk(1,0,0,0,0,1,5'd12,0), "R8 producer", n, sq);
    issue(mk(0,1,5'd12,1,5'd12,0,0,0), "R8 idle reader", n, sq);
    check_int("R8", "idle stalls", n, 0);

    // R6: stalled instruction counted once, when it advances
    issue(mk(1,0,0,0,0,1,5'd2,0), "R6 producer", n, sq);
    issue(mk(1,1,5'd2,0,0,1,5'd2,0), "R6 middle", n, sq);
    check_int("R6", "middle stalls", n, 2);
    issue(mk(1,1,5'd2,0,0,0,0,0), "R6 last", n, sq);
    check_int("R6", "last stalls", n, 2);

    // R7: squash window for a PC writer
    issue(mk(1,0,0,0,0,0,0,1), "R7 branch", n, sq);
    check_bit("R7", "squash at branch", sq, 1'b1);
    issue(idle_i, "R7 slot1", n, sq);
    check_bit("R7", "squash slot1", sq, 1'b1);
    issue(idle_i, "R7 slot2", n, sq);
    check_bit("R7", "squash slot2", sq, 1'b1);
    issue(idle_i, "R7 after", n, sq);
    check_bit("R7", "squash after window", sq, 1'b0);

    // R7 with a stalled PC writer
    issue(mk(1,0,0,0,0,1,5'd4,0), "R7 producer", n, sq);
    issue(mk(1,1,5'd4,0,0,0,0,1), "R7 stalled branch", n, sq);
    check_int("R7", "stalled branch stalls", n, 2);
    issue(idle_i, "R7 s1", n, sq);
    issue(idle_i, "R7 s2", n, sq);
    issue(idle_i, "R7 s3", n, sq);
    check_bit("R7", "squash cleared", sq, 1'b0);

    // random stream, R2 R3 R7 mixed
    void'($urandom(32'h5eed_1234));
    sq = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      ins_t r;
      r.v    = sq ? 1'b0 : ($urandom_range(9) != 0);
      r.a_en = $urandom_range(1);
      r.b_en = $urandom_range(1);
      r.a    = REG_W'($urandom_range(3));
      r.b    = REG_W'($urandom_range(3));
      r.wen  = $urandom_range(1);
      r.rd   = REG_W'($urandom_range(3));
      r.pcw  = ($urandom_range(11) == 0);
      issue(r, "R2 R3 R7 random", n, sq);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule